// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a register-mapped master for Clause 22 station-management transfers on a two-wire management bus. Software places one 32-bit frame word in the frame register. That word holds start, opcode, PHY address, register address, turnaround and data. The write launches a serial transaction. The controller derives MDC from the system clock with a programmable divider and moves the MDIO output a programmable number of clocks after each falling MDC edge. It can either send or skip the 32-bit preamble of ones.

When the frame's opcode selects a read, the controller releases MDIO from the turnaround field onward. It captures 16 bits from the PHY on rising MDC edges and returns them in the low half of the same frame register. Every finished transaction sets a sticky completion event, which software clears by writing one to it. An interrupt follows the event when the mask bit allows it.

The sequencer is a state machine with six states:
- `ST_IDLE`: no transfer is active.
- `ST_PREAMBLE`: the 32 leading ones are being sent.
- `ST_HEADER`: start, opcode and the two address fields are being sent.
- `ST_TURN`: the two turnaround bits.
- `ST_DATA`: the 16 data bits.
- `ST_DONE`: a single-cycle wrap-up state.

Its transitions are:
- Launch: from `ST_IDLE` to `ST_PREAMBLE`, or straight to `ST_HEADER` when the preamble is suppressed.
- Phase advance: from one phase to the next when the hold timer moves the bit index across a field boundary.
- Last-fall: from any active phase to `ST_DONE` on the falling MDC edge of the last bit.
- Release: from `ST_DONE` to `ST_IDLE`.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The 32 bits of the frame register (frame[31:30] start, frame[29:28] opcode, frame[27:23] PHY address, frame[22:18] register address, frame[17:16] turnaround, frame[15:0] data) go out MSB first, one bit per MDC cycle, and MDIO is valid at each rising MDC edge. For a write, all 32 bits are driven as written.
- R2: While speed[16] is 0, 32 one bits precede frame[31], giving 64 MDC cycles per transaction. While speed[16] is 1, the preamble is skipped and a transaction is 32 MDC cycles.
- R3: Opcode frame[29:28] = 10 selects a read. From the first turnaround bit onward the output enable is low. The 16 bits on mdio_i at the rising MDC edges of the data field are stored MSB first into frame[15:0], and frame[31:16] is kept.
- R4: The divider N sits in speed[5:0]. MDC is high for N+1 and low for N+1 system clocks, so its period is 2(N+1). MDC is low and MDIO is released whenever no transfer is active.
- R5: The hold value H sits in speed[10:8] and must be below N. Each new MDIO output bit appears exactly H+1 system clocks after the falling MDC edge that ends the previous bit.
- R6: The completion event (address 2, bit 0) becomes 1 in the clock after the last falling MDC edge. The busy bit (address 2, bit 1) is 1 from the launch edge until that same edge.
- R7: Writing 1 to event bit 0 clears it, and writing 0 leaves it unchanged. A clear in the same cycle as a completion leaves the event set.
- R8: irq is 1 exactly while the completion event is set and mask bit 0 at address 3 is set.
- R9: A frame-register write while busy is ignored: neither the running transfer nor the frame register changes.
- R10: While N is 0, a frame-register write starts nothing and is discarded: MDC stays low, busy stays 0 and the frame register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 frame, 1 speed, 2 event/busy, 3 mask |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq | output | 1 | Completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two functions can fall in the same cycle. A completion can set the event bit in the very clock in which software writes one to clear it. The bench provokes this by placing the clearing write on the bus at the sample where it sees the last falling MDC edge, so the write lands on the edge where the event sets. It then expects the event to read 1 afterwards. Randomized transfers also send a frame write in the middle of a transfer, and the bench judges that collision by the bits seen on MDIO and by the frame register read back at the end.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int BUS_W      = 32;
    localparam int FRAME_W    = 32;
    localparam int PRE_LEN    = 32;
    localparam int TOTAL_BITS = PRE_LEN + FRAME_W;
    localparam int IDX_W      = $clog2(TOTAL_BITS);
    localparam int FIDX_W     = $clog2(FRAME_W);

    // frame field positions that the serial order depends on
    localparam int OP_MSB     = 29;
    localparam int TA_MSB     = 17;
    localparam int TURN_IDX   = TOTAL_BITS - 1 - TA_MSB;
    localparam int DATA_IDX   = TURN_IDX + 2;
    localparam int DATA_W     = 16;
    localparam logic [1:0] OP_RD = 2'b10;

    // speed register layout
    localparam int SPD_HOLD_LSB = 8;
    localparam int SPD_PRE_BIT  = 16;

    // event/busy register layout
    localparam int EVT_BIT  = 0;
    localparam int BUSY_BIT = 1;

    typedef enum logic [1:0] {
        A_FRAME = 2'd0,
        A_SPEED = 2'd1,
        A_EVENT = 2'd2,
        A_MASK  = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } xfer_state_e;

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             at_end;

    assign at_end = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc       = mdc_q;
    assign rise_tick = at_end && !mdc_q;
    assign fall_tick = at_end &&  mdc_q;

endmodule

// File: rtl/mdio_hold_timer.sv
module mdio_hold_timer #(
    parameter int HOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              arm,
    input  logic [HOLD_W-1:0] hold,
    output logic              step
);

    logic [HOLD_W-1:0] cnt_q;
    logic              pend_q;

    assign step = pend_q && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (clear) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (arm) begin
            cnt_q  <= hold;
            pend_q <= 1'b1;
        end else if (step) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               pre_off,
    input  logic               is_read,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               step,
    output logic               busy,
    output logic               run,
    output logic               arm,
    output logic               done,
    output logic               sample_en,
    output logic               mdio_o,
    output logic               mdio_oe
);

    xfer_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             last;

    function automatic xfer_state_e phase_of(input logic [IDX_W-1:0] idx);
        if (int'(idx) < PRE_LEN)       return ST_PREAMBLE;
        else if (int'(idx) < TURN_IDX) return ST_HEADER;
        else if (int'(idx) < DATA_IDX) return ST_TURN;
        else                           return ST_DATA;
    endfunction

    assign last = (idx_q == IDX_W'(TOTAL_BITS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (pre_off) begin
                        state_d = ST_HEADER;
                        idx_d   = IDX_W'(PRE_LEN);
                    end else begin
                        state_d = ST_PREAMBLE;
                        idx_d   = '0;
                    end
                end
            end
            ST_PREAMBLE, ST_HEADER, ST_TURN, ST_DATA: begin
                if (fall_tick && last) begin
                    state_d = ST_DONE;
                end else if (step) begin
                    idx_d   = idx_q + 1'b1;
                    state_d = phase_of(idx_d);
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        logic active;
        logic released;
        logic bit_val;
        active   = 1'b0;
        released = 1'b0;
        bit_val  = frame_bits[~idx_q[FIDX_W-1:0]];
        unique case (state_q)
            ST_IDLE:     active = 1'b0;
            ST_PREAMBLE: begin active = 1'b1; bit_val = 1'b1; end
            ST_HEADER:   active = 1'b1;
            ST_TURN:     begin active = 1'b1; released = is_read; end
            ST_DATA:     begin active = 1'b1; released = is_read; end
            ST_DONE:     active = 1'b0;
            default:     active = 1'b0;
        endcase
        busy      = (state_q != ST_IDLE);
        run       = active;
        arm       = fall_tick && !last;
        done      = (state_q == ST_DONE);
        sample_en = rise_tick && is_read && (state_q == ST_DATA);
        mdio_oe   = active && !released;
        mdio_o    = mdio_oe && bit_val;
    end

endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W  = 6,
    parameter int HOLD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic               busy,
    input  logic               done,
    input  logic               sample_en,
    input  logic               sample_bit,
    output logic               start,
    output logic [FRAME_W-1:0] frame_q,
    output logic [DIV_W-1:0]   div_q,
    output logic [HOLD_W-1:0]  hold_q,
    output logic               pre_off_q,
    output logic               evt_q,
    output logic               irq
);

    logic mask_q;
    logic wr_frame, wr_speed, wr_event, wr_mask;

    assign wr_frame = bus_wr && (bus_addr == A_FRAME);
    assign wr_speed = bus_wr && (bus_addr == A_SPEED);
    assign wr_event = bus_wr && (bus_addr == A_EVENT);
    assign wr_mask  = bus_wr && (bus_addr == A_MASK);

    // a frame write is taken only when it launches a transfer
    assign start = wr_frame && !busy && (div_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (start) begin
            frame_q <= bus_wdata;
        end else if (sample_en) begin
            frame_q[DATA_W-1:0] <= {frame_q[DATA_W-2:0], sample_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= '0;
            hold_q    <= '0;
            pre_off_q <= 1'b0;
        end else if (wr_speed) begin
            div_q     <= bus_wdata[DIV_W-1:0];
            hold_q    <= bus_wdata[SPD_HOLD_LSB +: HOLD_W];
            pre_off_q <= bus_wdata[SPD_PRE_BIT];
        end
    end

    // completion has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else if (done) begin
            evt_q <= 1'b1;
        end else if (wr_event && bus_wdata[EVT_BIT]) begin
            evt_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (wr_mask) begin
            mask_q <= bus_wdata[0];
        end
    end

    assign irq = evt_q && mask_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_FRAME: bus_rdata = frame_q;
            A_SPEED: begin
                bus_rdata[DIV_W-1:0]               = div_q;
                bus_rdata[SPD_HOLD_LSB +: HOLD_W]  = hold_q;
                bus_rdata[SPD_PRE_BIT]             = pre_off_q;
            end
            A_EVENT: begin
                bus_rdata[EVT_BIT]  = evt_q;
                bus_rdata[BUSY_BIT] = busy;
            end
            A_MASK:  bus_rdata[0] = mask_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W  = 6,
    parameter int HOLD_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic               start, busy, run, arm, done, sample_en, step;
    logic               rise_tick, fall_tick;
    logic [FRAME_W-1:0] frame_q;
    logic [DIV_W-1:0]   div_q;
    logic [HOLD_W-1:0]  hold_q;
    logic               pre_off_q, evt_q, is_read, div_zero;

    assign is_read  = (frame_q[OP_MSB -: 2] == OP_RD);
    assign div_zero = (div_q == '0);

    mdio_mgmt_regs #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .done       (done),
        .sample_en  (sample_en),
        .sample_bit (mdio_i),
        .start      (start),
        .frame_q    (frame_q),
        .div_q      (div_q),
        .hold_q     (hold_q),
        .pre_off_q  (pre_off_q),
        .evt_q      (evt_q),
        .irq        (irq)
    );

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!run),
        .arm   (arm),
        .hold  (hold_q),
        .step  (step)
    );

    mdio_frame_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pre_off    (pre_off_q),
        .is_read    (is_read),
        .frame_bits (frame_q),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .step       (step),
        .busy       (busy),
        .run        (run),
        .arm        (arm),
        .done       (done),
        .sample_en  (sample_en),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        evt,
    input logic        done,
    input logic        sample_en,
    input logic [15:0] frame_hi,
    input logic        div_zero
);

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R6
    evt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt) |-> $past(done));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> evt);

    // R9
    frame_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(frame_hi));

    // R3
    sample_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> !mdio_oe);

    // R10
    div_zero_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && div_zero) |=> !busy);

endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .evt       (evt_q),
    .done      (done),
    .sample_en (sample_en),
    .frame_hi  (frame_q[31:16]),
    .div_zero  (div_zero)
);

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mdio_mgmt_master dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int pos, input logic [31:0] fr);
        if (pos < 32) return 1'b1;
        return fr[63 - pos];
    endfunction

    function automatic logic [31:0] mk_frame(input bit rd, input logic [4:0] pa,
                                             input logic [4:0] ra, input logic [15:0] wd);
        return {2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_xfer(input int n, input int h, input bit pre_off, input bit rd,
                            input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] wd, input logic [15:0] phy,
                            input bit msk, input bit intrude, input bit clr_same);
        logic [31:0] fr, st, rb, expv;
        int total, offset, rises, falls, since_rise, since_fall, guard, pos;
        int bad_gap, bad_hold;
        bit prev_mdc, prev_o, prev_oe, bits_ok, oe_ok, per_ok, hold_ok, fin, did;
        fr = mk_frame(rd, pa, ra, wd);
        total = pre_off ? 32 : 64;
        offset = pre_off ? 32 : 0;
        rises = 0; falls = 0; since_rise = 0; since_fall = -1; guard = 0;
        bad_gap = 0; bad_hold = 0;
        prev_mdc = 0; prev_o = 0; prev_oe = 0;
        bits_ok = 1; oe_ok = 1; per_ok = 1; hold_ok = 1; fin = 0; did = 0;
        bus_write(2'd1, 32'(n) | (32'(h) << 8) | (32'(pre_off) << 16));
        bus_write(2'd3, 32'(msk));
        bus_write(2'd2, 32'd1);
        mdio_i = 1'b1;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = fr;
        while (!fin && guard < 6000) begin
            @(negedge clk);
            guard++;
            bus_wr = 1'b0;
            bus_addr = 2'd2;
            #1;
            st = bus_rdata;
            since_rise++;
            if (since_fall >= 0) since_fall++;
            if (mdc && !prev_mdc) begin
                pos = offset + rises;
                if (rd && pos >= 46) begin
                    if (mdio_oe) oe_ok = 0;
                end else begin
                    if (!mdio_oe) oe_ok = 0;
                    if (mdio_o != exp_bit(pos, fr)) bits_ok = 0;
                end
                if (rises > 0 && since_rise != 2 * (n + 1)) begin
                    per_ok = 0; bad_gap = since_rise;
                end
                rises++;
                since_rise = 0;
            end
            if (!mdc && prev_mdc) begin
                falls++;
                since_fall = 0;
                if (falls == total) begin
                    // R6: still busy, event not yet set in the DONE cycle
                    check(st[1] == 1'b1 && st[0] == 1'b0, "R6", "status at last fall",
                          st[1:0], 2'b10);
                    if (clr_same) begin
                        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'd1;
                    end
                end
            end else if (falls == total && since_fall == 1) begin
                check(st[1:0] == 2'b01, clr_same ? "R7" : "R6",
                      "status one clock after last fall", st[1:0], 2'b01);
                check(irq == msk, "R8", "irq after completion", irq, msk);
                fin = 1;
            end
            if (mdio_oe && prev_oe && (mdio_o != prev_o) && since_fall >= 0) begin
                if (since_fall != h + 1) begin
                    hold_ok = 0; bad_hold = since_fall;
                end
            end
            if (intrude && !did && rises == 5) begin
                bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = ~fr;
                did = 1;
            end
            if (rd) begin
                pos = offset + rises;
                mdio_i = (pos >= 48 && pos < 64) ? phy[63 - pos] : 1'b1;
            end
            prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
        end
        check(fin, "R6", "transfer completed", fin, 1);
        check(bits_ok, "R1", "bits on MDIO at rising MDC", bits_ok, 1);
        check(oe_ok, "R3", "output enable pattern", oe_ok, 1);
        check(per_ok, "R4", "MDC period", bad_gap, 2 * (n + 1));
        check(hold_ok, "R5", "MDIO hold after falling MDC", bad_hold, h + 1);
        check(rises == total, "R2", "MDC cycles per transaction", rises, total);
        bus_read(2'd0, rb);
        expv = rd ? {fr[31:16], phy} : fr;
        check(rb == expv, intrude ? "R9" : (rd ? "R3" : "R1"), "frame register readback", rb, expv);
        mdio_i = 1'b1;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        bit saw;
        int n, h;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        bus_read(2'd0, rv);
        check(rv == 32'd0, "R10", "frame after reset", rv, 0);
        bus_read(2'd2, rv);
        check(rv[1:0] == 2'b00, "R6", "event/busy after reset", rv[1:0], 0);
        check(mdc == 1'b0 && mdio_oe == 1'b0 && irq == 1'b0, "R4", "pins after reset",
              {mdc, mdio_oe, irq}, 0);

        // R10: divider 0 blocks the launch
        bus_write(2'd1, 32'd0);
        bus_write(2'd0, mk_frame(1'b0, 5'd3, 5'd4, 16'hA5A5));
        saw = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mdc || mdio_oe) saw = 1;
        end
        check(!saw, "R10", "MDC activity with divider 0", saw, 0);
        bus_read(2'd2, rv);
        check(rv[1] == 1'b0, "R10", "busy with divider 0", rv[1], 0);
        bus_read(2'd0, rv);
        check(rv == 32'd0, "R10", "frame kept with divider 0", rv, 0);

        // directed corner cases
        run_xfer(1, 0, 1'b0, 1'b0, 5'h1F, 5'h00, 16'h8001, 16'h0, 1'b1, 1'b0, 1'b0);
        run_xfer(7, 6, 1'b1, 1'b1, 5'h05, 5'h1F, 16'h0000, 16'hC3A5, 1'b0, 1'b0, 1'b0);
        run_xfer(3, 1, 1'b0, 1'b1, 5'h11, 5'h0A, 16'hFFFF, 16'h1234, 1'b1, 1'b1, 1'b0);
        run_xfer(2, 1, 1'b1, 1'b0, 5'h0C, 5'h13, 16'h5A5A, 16'h0, 1'b1, 1'b0, 1'b1);

        // R7: write 0 keeps the event, write 1 clears it
        bus_write(2'd2, 32'd0);
        bus_read(2'd2, rv);
        check(rv[0] == 1'b1, "R7", "event after writing 0", rv[0], 1);
        // R8: mask gates the interrupt
        bus_write(2'd3, 32'd0);
        check(irq == 1'b0, "R8", "irq with mask clear", irq, 0);
        bus_write(2'd3, 32'd1);
        check(irq == 1'b1, "R8", "irq with mask set", irq, 1);
        bus_write(2'd2, 32'd1);
        bus_read(2'd2, rv);
        check(rv[0] == 1'b0, "R7", "event after writing 1", rv[0], 0);
        check(irq == 1'b0, "R8", "irq after clear", irq, 0);

        // constrained random transfers
        for (int k = 0; k < 24; k++) begin
            n = 2 + int'($urandom % 6);
            h = int'($urandom % n);
            run_xfer(n, h, 1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom),
                     16'($urandom), 16'($urandom), 1'($urandom),
                     ($urandom % 4) == 0, ($urandom % 5) == 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule